// File: doc/BRIEF.md
# LIN Transmit Short-Circuit Detector

This block guards a LIN transmitter while the node is sending frames. It looks for a short on the bus wire. A short needs two signs at once: the overcurrent comparator of the output stage is raised, and the bus reads recessive while the node drives dominant. If both signs stay present for a software-chosen number of debounce ticks, the block treats the short as real. It then sets a sticky fault flag, pulses an interrupt request and turns the transmitter off.

The transmit data from the controller passes through the block to the driver. While the fault flag is set, the driver input is forced to recessive and the enable output goes low. Software acknowledges the fault by pulsing a write-one-to-clear strobe, and that reopens the transmitter. The debounce length comes from a 3-bit selector that picks a power of two, from 1 to 128 ticks.

Top module: `lin_txshort_guard`

## Requirements
- R1: After reset, `short_flag` = 0, `short_irq` = 0, `tx_en` = 1, and `drv_txd` equals `txd`.
- R2: A tick counts toward a short only when all four hold together: `tx_active` = 1, `ovc` = 1, `txd` = 0 (dominant) and `rxd` = 1 (recessive). Dominant is logic 0 and recessive is logic 1 on both `txd` and `rxd`.
- R3: `short_flag` rises at the clock edge that samples the 2^`dbnc_sel`-th consecutive qualifying tick. With `dbnc_sel` = 0, one tick is enough. With `dbnc_sel` = 7, 128 ticks are needed.
- R4: If the fault condition drops for any cycle during the window, the tick count restarts from zero.
- R5: `short_irq` is a one-cycle pulse. It is raised in the same cycle that `short_flag` first reads 1.
- R6: `short_flag` stays at 1 until a cycle with `flag_clr` = 1 clears it. While the flag is 0, `flag_clr` has no effect.
- R7: While `short_flag` = 1, `tx_en` = 0 and `drv_txd` = 1 whatever `txd` is. While `short_flag` = 0, `tx_en` = 1 and `drv_txd` follows `txd`.
- R8: Ticks are not counted while the flag is set. After a clear, a new short needs a full debounce window, even if the condition was present the whole time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_active | input | 1 | Node is transmitting a frame |
| txd | input | 1 | Transmit data from the controller (0 = dominant) |
| rxd | input | 1 | Sampled bus level (0 = dominant) |
| ovc | input | 1 | Output-stage overcurrent comparator |
| tick | input | 1 | Debounce time-base strobe, one cycle wide |
| dbnc_sel | input | 3 | Debounce length selector: 2^value ticks |
| flag_clr | input | 1 | Write-one-to-clear strobe for the fault flag |
| drv_txd | output | 1 | Gated transmit data to the driver |
| tx_en | output | 1 | Transmitter enable |
| short_flag | output | 1 | Sticky short fault flag |
| short_irq | output | 1 | One-cycle interrupt pulse on confirmation |

## Verification
The assertions check four things on every cycle:
- the interrupt is a single cycle wide and comes together with the flag;
- the flag never drops without a clear strobe;
- the flag never rises unless the previous cycle had a qualifying tick;
- the transmitter gate always matches the flag.

Only the bench scenarios can show the rest. These are the exact tick count for each selector value, the restart of the window after a short gap in the condition, and the need for a full new window after a clear.

// File: rtl/lin_short_pkg.sv
// Package: shared helpers for the LIN short detector.
// Assumes the debounce selector is an exponent of two.
package lin_short_pkg;

    // Width of the debounce selector field.
    localparam int DBNC_SEL_W = 3;

    // Number of ticks selected by a selector value (2^sel).
    function automatic int dbnc_ticks(input int sel);
        return 1 << sel;
    endfunction

endpackage

// File: rtl/lin_short_qual.sv
// Module: lin_short_qual
// Combines the transmitter and bus signals into one fault-present level.
// Assumes dominant = 0 and recessive = 1 on txd and rxd.
module lin_short_qual (
    input  logic tx_active,
    input  logic ovc,
    input  logic txd,
    input  logic rxd,
    output logic fault
);

    // Fault needs overcurrent plus a sent-dominant / read-recessive mismatch while sending.
    always_comb begin
        fault = tx_active & ovc & ~txd & rxd;
    end

endmodule

// File: rtl/lin_short_dbnc.sv
// Module: lin_short_dbnc
// Counts consecutive qualifying ticks and signals when the selected window is full.
// Assumes tick is a single-cycle strobe. hold freezes and clears the count.
module lin_short_dbnc #(
    parameter int SEL_W = 3,
    localparam int CNT_W = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault,
    input  logic             tick,
    input  logic             hold,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;

    // Index of the final tick in the window: 2^sel - 1.
    always_comb begin
        last_idx = (CNT_W'(1) << sel) - CNT_W'(1);
    end

    // Window is complete when the last qualifying tick arrives.
    always_comb begin
        hit = fault & tick & ~hold & (cnt == last_idx);
    end

    // Tick counter: clears on a gap, on hold or on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!fault || hold || hit) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lin_short_latch.sv
// Module: lin_short_latch
// Holds the sticky short flag and produces the one-cycle interrupt pulse.
// Assumes hit arrives only while the flag is clear.
module lin_short_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flag_clr,
    output logic short_flag,
    output logic short_irq
);

    // Sticky flag: set by hit, cleared only by the write-one strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_flag <= 1'b0;
        end else if (hit) begin
            short_flag <= 1'b1;
        end else if (flag_clr) begin
            short_flag <= 1'b0;
        end
    end

    // Interrupt pulse: one cycle, on the edge that sets the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_irq <= 1'b0;
        end else begin
            short_irq <= hit & ~short_flag;
        end
    end

endmodule

// File: rtl/lin_txshort_guard.sv
// Module: lin_txshort_guard (top)
// Detects a debounced LIN transmit short and shuts off the transmitter until the fault is acknowledged.
// Assumes all inputs are synchronous to clk.
module lin_txshort_guard #(
    parameter int SEL_W = lin_short_pkg::DBNC_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_active,
    input  logic             txd,
    input  logic             rxd,
    input  logic             ovc,
    input  logic             tick,
    input  logic [SEL_W-1:0] dbnc_sel,
    input  logic             flag_clr,
    output logic             drv_txd,
    output logic             tx_en,
    output logic             short_flag,
    output logic             short_irq
);

    logic fault;
    logic hit;

    lin_short_qual u_qual (
        .tx_active (tx_active),
        .ovc       (ovc),
        .txd       (txd),
        .rxd       (rxd),
        .fault     (fault)
    );

    lin_short_dbnc #(.SEL_W(SEL_W)) u_dbnc (
        .clk   (clk),
        .rst_n (rst_n),
        .fault (fault),
        .tick  (tick),
        .hold  (short_flag),
        .sel   (dbnc_sel),
        .hit   (hit)
    );

    lin_short_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .flag_clr   (flag_clr),
        .short_flag (short_flag),
        .short_irq  (short_irq)
    );

    // Transmitter gate: force recessive and disable while a short is flagged.
    always_comb begin
        tx_en   = ~short_flag;
        drv_txd = short_flag ? 1'b1 : txd;
    end

endmodule

// File: rtl/lin_txshort_guard_chk.sv
// Module: lin_txshort_guard_chk
// Checker for the short detector's ports, attached to the top by bind.
module lin_txshort_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_active,
    input logic txd,
    input logic rxd,
    input logic ovc,
    input logic tick,
    input logic flag_clr,
    input logic drv_txd,
    input logic tx_en,
    input logic short_flag,
    input logic short_irq
);

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        short_irq |=> !short_irq); // R5
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        short_irq |-> short_flag); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (short_flag && !flag_clr) |=> short_flag); // R6
    AST_FLAG_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!short_flag && !(tx_active && ovc && !txd && rxd && tick)) |=> !short_flag); // R2
    AST_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        short_flag |-> (!tx_en && drv_txd)); // R7
    AST_TX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !short_flag |-> (tx_en && (drv_txd == txd))); // R7

endmodule

bind lin_txshort_guard lin_txshort_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_active  (tx_active),
    .txd        (txd),
    .rxd        (rxd),
    .ovc        (ovc),
    .tick       (tick),
    .flag_clr   (flag_clr),
    .drv_txd    (drv_txd),
    .tx_en      (tx_en),
    .short_flag (short_flag),
    .short_irq  (short_irq)
);

// File: tb/lin_txshort_guard_test.sv
// Bench for lin_txshort_guard: a vector table plus directed corner cases.
module lin_txshort_guard_test;

    localparam int CLK_PER = 10;
    localparam int NVEC = 10;
    // Vector fields: [15] act, [14] ovc, [13] txd, [12] rxd, [11:9] sel, [8:1] ticks, [0] expected flag
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 8'd1,   1'b1},
        {1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 8'd4,   1'b0},
        {1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 8'd4,   1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 8'd4,   1'b0},
        {1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 8'd4,   1'b0},
        {1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 8'd3,   1'b0},
        {1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 8'd4,   1'b1},
        {1'b1, 1'b1, 1'b0, 1'b1, 3'd7, 8'd127, 1'b0},
        {1'b1, 1'b1, 1'b0, 1'b1, 3'd7, 8'd128, 1'b1},
        {1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 8'd2,   1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_active = 1'b0;
    logic       txd = 1'b1;
    logic       rxd = 1'b1;
    logic       ovc = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] dbnc_sel = 3'd0;
    logic       flag_clr = 1'b0;
    logic       drv_txd;
    logic       tx_en;
    logic       short_flag;
    logic       short_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PER / 2) clk = ~clk;

    lin_txshort_guard uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_active  (tx_active),
        .txd        (txd),
        .rxd        (rxd),
        .ovc        (ovc),
        .tick       (tick),
        .dbnc_sel   (dbnc_sel),
        .flag_clr   (flag_clr),
        .drv_txd    (drv_txd),
        .tx_en      (tx_en),
        .short_flag (short_flag),
        .short_irq  (short_irq)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Synchronous reset for two cycles. Inputs are driven at the falling edge.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // n single-cycle ticks, each followed by an idle cycle. Ends at a falling edge.
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // Drive the full fault condition.
    task automatic set_fault();
        tx_active = 1'b1; ovc = 1'b1; txd = 1'b0; rxd = 1'b1;
    endtask

    initial begin
        // R1: reset state
        do_reset();
        @(negedge clk);
        chk("R1 flag", short_flag, 1'b0);
        chk("R1 irq", short_irq, 1'b0);
        chk("R1 tx_en", tx_en, 1'b1);
        txd = 1'b0; #1;
        chk("R1 drv_txd dominant", drv_txd, 1'b0);
        txd = 1'b1; #1;
        chk("R1 drv_txd recessive", drv_txd, 1'b1);

        // R2/R3: vector table
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            tx_active = VEC[v][15]; ovc = VEC[v][14];
            txd = VEC[v][13]; rxd = VEC[v][12];
            dbnc_sel = VEC[v][11:9];
            ticks(int'(VEC[v][8:1]));
            chk($sformatf("R2/R3 vec%0d flag", v), short_flag, VEC[v][0]);
            chk($sformatf("R7 vec%0d tx_en", v), tx_en, ~VEC[v][0]);
        end

        // R5: interrupt pulse
        do_reset();
        dbnc_sel = 3'd0; set_fault();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R5 irq raised", short_irq, 1'b1);
        chk("R5 flag with irq", short_flag, 1'b1);
        @(negedge clk);
        chk("R5 irq dropped", short_irq, 1'b0);

        // R7: gate while flagged
        txd = 1'b0; #1;
        chk("R7 drv_txd forced recessive", drv_txd, 1'b1);
        chk("R7 tx_en low", tx_en, 1'b0);

        // R6: sticky flag, then cleared
        repeat (5) @(negedge clk);
        chk("R6 flag holds", short_flag, 1'b1);
        dbnc_sel = 3'd2;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R6 flag cleared", short_flag, 1'b0);
        chk("R7 tx_en restored", tx_en, 1'b1);

        // R8: a full new window is needed after a clear
        ticks(3);
        chk("R8 short window after clear", short_flag, 1'b0);
        ticks(1);
        chk("R8 full window after clear", short_flag, 1'b1);

        // R6: clear while flag is 0 has no effect
        do_reset();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R6 clear no-op", short_flag, 1'b0);

        // R4: a gap restarts the count
        do_reset();
        dbnc_sel = 3'd2; set_fault();
        ticks(3);
        ovc = 1'b0;
        @(negedge clk);
        ovc = 1'b1;
        ticks(3);
        chk("R4 restart after gap", short_flag, 1'b0);
        ticks(1);
        chk("R4 full window after gap", short_flag, 1'b1);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule